// File: doc/BRIEF.md
# SCL Timing Generator

This block sets the SCL waveform for an I2C master. Its clock comes from a programmed baud count and a two-bit speed mode. It pulls SCL low for the low phase and then releases the line. It waits for the line to read high, which lets a slave stretch the clock, and then waits a programmed setup count. After that it holds the high phase. It gives the bit engine two single-cycle strobes: one marks where SDA may change during the low phase, and one marks where SDA is sampled during the high phase.

Each phase length is a whole number of baud counts. In standard mode the low phase and the high phase are each one count long. In the fast modes the low phase is two counts and the high phase is one count. The high-speed mode value has no timing of its own here and behaves as standard mode. The configuration inputs are expected to stay stable while the block runs. The run input is looked at only at the end of a high phase, so a stop request always completes the current SCL period first.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and while `run` has never been sampled high, `scl_oe` is 0 and neither tick strobe is asserted.
- R2: With `spd_mode` = 0 (standard) and effective baud count B, `scl_oe` is 1 for exactly B cycles, and the high phase lasts exactly B cycles.
- R3: With `spd_mode` = 1 (fast) or 3 (fast-plus), the low phase lasts 2·B cycles and the high phase lasts B cycles.
- R4: With `spd_mode` = 2 (high speed), the timing is identical to standard mode (low B, high B).
- R5: A `baud_cnt` of 0 behaves exactly like a `baud_cnt` of 1.
- R6: After the low phase ends, the block stays released and frozen for every cycle in which `scl_in` reads 0. The first cycle with `scl_in` = 1 ends the wait, so with no stretch the wait lasts one cycle.
- R7: Once `scl_in` has been seen high, the block waits `setup_cnt` + 1 cycles before the high phase starts, so a `setup_cnt` of 0 waits one cycle.
- R8: `chg_tick` is a single-cycle pulse at cycle index floor(L/2) of each low phase, where index 0 is the first low cycle and L is the low-phase length. It occurs only while `scl_oe` is 1.
- R9: `smp_tick` is a single-cycle pulse at cycle index floor(B/2) of each high phase, and it occurs only while SCL is released.
- R10: If `run` is 1 at the last high-phase cycle, the next low phase starts at once. If it is 0, the block goes idle with SCL released. A new low phase starts only one cycle after `run` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spd_mode | input | 2 | Speed mode: 0 standard, 1 fast, 2 high speed (runs as standard), 3 fast-plus |
| baud_cnt | input | 16 | Baud count B, in clock cycles per SCL count; 0 is treated as 1 |
| setup_cnt | input | 16 | Data setup wait after SCL is seen high; the wait is this value plus one cycle |
| run | input | 1 | Start and keep generating SCL periods; sampled at the end of each high phase |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | 1 drives SCL low, 0 releases it |
| chg_tick | output | 1 | Single-cycle strobe at the middle of the low phase |
| smp_tick | output | 1 | Single-cycle strobe at the middle of the high phase |

## Verification
All outputs are decoded directly from the state register. The first low cycle therefore appears one cycle after `run` is sampled high. Every later edge and tick falls at a fixed offset from that cycle: the change tick at floor(L/2), the release at L, and the sample tick at L + stretch + setup + 2 + floor(B/2). The next period starts after a total of L + stretch + setup + 2 + B cycles. The driver computes these absolute cycle numbers from the mode, the baud and setup counts, and the stretch length it applies, and queues them in event order. The monitor samples on the falling clock edge, timestamps each observed edge and tick, and matches it against the head of the queue, so both a late event and an unexpected event are reported.

// File: rtl/sclg_pkg.sv
package sclg_pkg;

    typedef enum logic [1:0] {
        SPD_STD   = 2'd0,
        SPD_FAST  = 2'd1,
        SPD_HS    = 2'd2,
        SPD_FPLUS = 2'd3
    } sclg_speed_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOW   = 3'd1,
        ST_REL   = 3'd2,
        ST_SETUP = 3'd3,
        ST_HIGH  = 3'd4
    } sclg_state_e;

    // Fast modes stretch the low phase to two baud counts.
    function automatic logic long_low(input logic [1:0] mode);
        return (mode == SPD_FAST) || (mode == SPD_FPLUS);
    endfunction

endpackage

// File: rtl/sclg_len_calc.sv
module sclg_len_calc
    import sclg_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic [1:0]       spd_mode,
    input  logic [CNT_W-1:0] baud_cnt,
    input  logic [CNT_W-1:0] setup_cnt,
    output logic [LEN_W-1:0] low_last,
    output logic [LEN_W-1:0] high_last,
    output logic [LEN_W-1:0] setup_last,
    output logic [LEN_W-1:0] low_mid,
    output logic [LEN_W-1:0] high_mid
);
    logic [LEN_W-1:0] b_eff;
    logic [LEN_W-1:0] l_len;

    always_comb begin
        b_eff      = (baud_cnt == '0) ? LEN_W'(1) : {1'b0, baud_cnt};
        l_len      = long_low(spd_mode) ? (b_eff << 1) : b_eff;
        low_last   = l_len - LEN_W'(1);
        high_last  = b_eff - LEN_W'(1);
        setup_last = {1'b0, setup_cnt};
        low_mid    = l_len >> 1;
        high_mid   = b_eff >> 1;
    end

endmodule

// File: rtl/sclg_phase_fsm.sv
module sclg_phase_fsm
    import sclg_pkg::*;
#(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             scl_in,
    input  logic [LEN_W-1:0] low_last,
    input  logic [LEN_W-1:0] high_last,
    input  logic [LEN_W-1:0] setup_last,
    output sclg_state_e      state,
    output logic [LEN_W-1:0] cnt
);
    sclg_state_e      state_nx;
    logic [LEN_W-1:0] cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt + LEN_W'(1);
        unique case (state)
            ST_IDLE: begin
                cnt_nx = '0;
                if (run) state_nx = ST_LOW;
            end
            ST_LOW: begin
                if (cnt >= low_last) begin
                    state_nx = ST_REL;
                    cnt_nx   = '0;
                end
            end
            ST_REL: begin
                cnt_nx = '0;
                if (scl_in) state_nx = ST_SETUP;
            end
            ST_SETUP: begin
                if (cnt >= setup_last) begin
                    state_nx = ST_HIGH;
                    cnt_nx   = '0;
                end
            end
            ST_HIGH: begin
                if (cnt >= high_last) begin
                    state_nx = run ? ST_LOW : ST_IDLE;
                    cnt_nx   = '0;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

endmodule

// File: rtl/sclg_tick_dec.sv
module sclg_tick_dec
    import sclg_pkg::*;
#(
    parameter int LEN_W = 17
) (
    input  sclg_state_e      state,
    input  logic [LEN_W-1:0] cnt,
    input  logic [LEN_W-1:0] low_mid,
    input  logic [LEN_W-1:0] high_mid,
    output logic             scl_oe,
    output logic             chg_tick,
    output logic             smp_tick
);
    always_comb begin
        scl_oe   = (state == ST_LOW);
        chg_tick = (state == ST_LOW)  && (cnt == low_mid);
        smp_tick = (state == ST_HIGH) && (cnt == high_mid);
    end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import sclg_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       spd_mode,
    input  logic [CNT_W-1:0] baud_cnt,
    input  logic [CNT_W-1:0] setup_cnt,
    input  logic             run,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             chg_tick,
    output logic             smp_tick
);
    logic [LEN_W-1:0] low_last, high_last, setup_last, low_mid, high_mid;
    logic [LEN_W-1:0] phase_cnt;
    sclg_state_e      fsm_state;

    sclg_len_calc #(.CNT_W(CNT_W)) u_len (
        .spd_mode   (spd_mode),
        .baud_cnt   (baud_cnt),
        .setup_cnt  (setup_cnt),
        .low_last   (low_last),
        .high_last  (high_last),
        .setup_last (setup_last),
        .low_mid    (low_mid),
        .high_mid   (high_mid)
    );

    sclg_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .scl_in     (scl_in),
        .low_last   (low_last),
        .high_last  (high_last),
        .setup_last (setup_last),
        .state      (fsm_state),
        .cnt        (phase_cnt)
    );

    sclg_tick_dec #(.LEN_W(LEN_W)) u_dec (
        .state    (fsm_state),
        .cnt      (phase_cnt),
        .low_mid  (low_mid),
        .high_mid (high_mid),
        .scl_oe   (scl_oe),
        .chg_tick (chg_tick),
        .smp_tick (smp_tick)
    );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
    import sclg_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic        scl_in,
    input logic        scl_oe,
    input logic        chg_tick,
    input logic        smp_tick,
    input sclg_state_e state
);
    p_reset_released_r1: assert property (@(posedge clk)
        $past(rst) |-> (!scl_oe && !chg_tick && !smp_tick));

    p_low_needs_run_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_oe) |-> $past(run));

    p_stretch_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REL && !scl_in) |=> (state == ST_REL));

    p_setup_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REL && scl_in) |=> (state == ST_SETUP));

    p_chg_in_low_r8: assert property (@(posedge clk) disable iff (rst)
        chg_tick |-> scl_oe);

    p_chg_single_r8: assert property (@(posedge clk) disable iff (rst)
        chg_tick |=> !chg_tick);

    p_smp_released_r9: assert property (@(posedge clk) disable iff (rst)
        smp_tick |-> (!scl_oe && !chg_tick));

    p_smp_single_r9: assert property (@(posedge clk) disable iff (rst)
        smp_tick |=> !smp_tick);

endmodule

bind scl_timing_gen scl_timing_gen_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .scl_in   (scl_in),
    .scl_oe   (scl_oe),
    .chg_tick (chg_tick),
    .smp_tick (smp_tick),
    .state    (fsm_state)
);

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        int    kind;   // 0 SCL driven low, 1 change tick, 2 SCL released, 3 sample tick
        int    t;
        string tag;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  spd_mode = 2'd0;
    logic [15:0] baud_cnt = 16'd1;
    logic [15:0] setup_cnt = 16'd0;
    logic        run = 1'b0;
    logic        scl_in;
    logic        scl_oe, chg_tick, smp_tick;

    int  hold_len = 0;
    int  hold_cnt;
    int  cyc = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  prev_oe = 1'b0;
    ev_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slave model: holds SCL low for hold_len cycles after the master lets go.
    always_ff @(posedge clk) begin
        if (rst)              hold_cnt <= 0;
        else if (scl_oe)      hold_cnt <= hold_len;
        else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1;
    end
    assign scl_in = !(scl_oe || (hold_cnt != 0));

    scl_timing_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .spd_mode  (spd_mode),
        .baud_cnt  (baud_cnt),
        .setup_cnt (setup_cnt),
        .run       (run),
        .scl_in    (scl_in),
        .scl_oe    (scl_oe),
        .chg_tick  (chg_tick),
        .smp_tick  (smp_tick)
    );

    task automatic observe(input int kind);
        ev_t e;
        n_checks++;
        if (expq.size() == 0) begin
            n_fail++;
            $display("FAIL R10: unexpected event kind %0d at cycle %0d, expected none", kind, cyc);
        end else begin
            e = expq.pop_front();
            if (e.kind != kind || e.t != cyc) begin
                n_fail++;
                $display("FAIL %s: event kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                         e.tag, kind, cyc, e.kind, e.t);
            end
        end
    endtask

    // Monitor: timestamps every edge and tick, compares with the queue head.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                if (scl_oe && !prev_oe) observe(0);
                if (chg_tick)           observe(1);
                if (!scl_oe && prev_oe) observe(2);
                if (smp_tick)           observe(3);
            end
            prev_oe = scl_oe;
        end
    end

    task automatic push(input int kind, input int t, input string tag);
        ev_t e;
        e.kind = kind;
        e.t    = t;
        e.tag  = tag;
        expq.push_back(e);
    endtask

    task automatic scenario(input int mode, input int baud, input int setup,
                            input int hold, input int periods, input string tag);
        int b, l, p, t0;
        b = (baud == 0) ? 1 : baud;
        l = (mode == 1 || mode == 3) ? 2 * b : b;
        p = l + hold + 1 + setup + 1 + b;
        @(negedge clk); #1;
        spd_mode  = 2'(mode);
        baud_cnt  = 16'(baud);
        setup_cnt = 16'(setup);
        hold_len  = hold;
        @(negedge clk); #1;
        t0 = cyc + 1;
        for (int k = 0; k < periods; k++) begin
            int tk;
            tk = t0 + k * p;
            push(0, tk, tag);
            push(1, tk + l / 2, "R8");
            push(2, tk + l, tag);
            push(3, tk + l + hold + setup + 2 + b / 2, "R9");
        end
        run = 1'b1;
        while (cyc < t0 + (periods - 1) * p) begin
            @(negedge clk); #1;
        end
        run = 1'b0;
        while (cyc < t0 + periods * p + 4) begin
            @(negedge clk); #1;
        end
        n_checks++;
        if (expq.size() != 0 || scl_oe) begin
            n_fail++;
            $display("FAIL R10: after stop pending=%0d scl_oe=%0b, expected pending=0 scl_oe=0",
                     expq.size(), scl_oe);
            expq.delete();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        // R1: idle after reset with run low
        n_checks++;
        if (scl_oe || chg_tick || smp_tick) begin
            n_fail++;
            $display("FAIL R1: oe=%0b chg=%0b smp=%0b, expected all 0", scl_oe, chg_tick, smp_tick);
        end
        scenario(0, 4, 0, 0, 2, "R2");
        scenario(1, 3, 1, 0, 2, "R3");
        scenario(3, 5, 0, 0, 1, "R3");
        scenario(2, 4, 0, 0, 1, "R4");
        scenario(0, 0, 0, 0, 2, "R5");
        scenario(1, 0, 2, 0, 1, "R5");
        scenario(0, 3, 0, 5, 2, "R6");
        scenario(1, 2, 6, 2, 1, "R7");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10: watchdog expired at cycle %0d, expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule